// File: doc/BRIEF.md
# Pipelined Converter Code Alignment and Correction

This block sits behind a nine-stage pipelined quantizer. Every conversion clock, each stage hands over a 2-bit code. Stage k produces its code for a given sample one clock after stage k-1, so one sample's codes arrive spread over nine consecutive edges. Each stage has its own delay line, and the lines are sized so that all nine codes of one sample leave together. The aligned codes are merged by overlap-add: each of stages 1 to 8 carries one redundant bit, which absorbs comparator offsets. The merged value is clamped into the 10-bit range and sent through a short output register chain. The result is a straight offset binary word, produced at a fixed latency.

A small sequencer with three named states judges whether the word on the output is valid. FILL waits out the pipeline after a reset or a wake-up. RUN marks the data as good. SLEEP covers power-down. The transitions are:
- reset → FILL.
- FILL → RUN ("fill done"), once the fill count is reached.
- FILL or RUN → SLEEP ("power down"), when the power-down input is sampled high.
- SLEEP → FILL ("wake"), when the power-down input is sampled low.

A drive-enable output tells the pad ring when the data bus may be driven. It is low whenever the output-disable input is high or power-down is asserted.

Top module: `ecc_corrector`

## Requirements
- R1: The code of stage k (bits [2k-1:2k-2] of `stage_codes`, stage 1 in bits [1:0]) for a sample is presented one clock after that sample's code of stage k-1. The block combines exactly the nine codes belonging to one sample into one output word.
- R2: For stages 1 to 8, codes 00, 01 and 10 count as digits 0, 1 and 2, with weight 2^(9-k). The 2-bit code of stage 9 adds with weight 1. Examples: all of stages 1-8 at 01 with stage 9 at 10 gives 0x200; all at 10 with stage 9 at 11 gives 0x3FF; all zero gives 0x000.
- R3: Code 11 in stages 1 to 8 is an out-of-range mark. In stage 1 it counts as digit 3. In a later stage it counts as digit 3 when the preceding stage's code has its upper bit set, and as digit -1 otherwise.
- R4: A merged sum above 0x3FF yields 0x3FF, and a sum below zero yields 0x000. There is no wrap-around.
- R5: A sample's word appears on `dout` after the fifth rising edge, counting the edge that captures the sample's stage-9 code as the first.
- R6: While `oe_n` is high, `dout_oe` is low. The data path keeps running, and `dout` keeps carrying corrected words.
- R7: While `pwrdn` is high, `dout_oe` is low in the same cycle. After any edge that samples `pwrdn` high, `dvalid` is low (state SLEEP).
- R8: After the first edge that samples `pwrdn` low, the next five output words are marked invalid. `dvalid` rises after the fifth edge following that one (FILL, then RUN).
- R9: A synchronous reset clears every delay line and output register to zero and lowers `dvalid`. After reset is released, `dout` stays zero and `dvalid` stays low through the fourth edge. `dvalid` rises after the fifth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| stage_codes | input | 18 | Raw 2-bit codes of the nine stages, stage k at bits [2k-1:2k-2] |
| oe_n | input | 1 | Output disable, active high |
| pwrdn | input | 1 | Power-down request, active high |
| dout | output | 10 | Corrected straight offset binary word |
| dout_oe | output | 1 | Drive enable for the data pads |
| dvalid | output | 1 | Marks `dout` as a valid word |

## Verification
The checker assumes that `rst` and `pwrdn` are sampled only on rising edges. It also assumes that `pwrdn` may rise in either FILL or RUN, and that `oe_n` may toggle at any time with no effect on the data path. The stimulus changes every input only at falling edges. It drives `stage_codes` from a history of pushed samples, staggered one clock per stage, and it raises reset or power-down only after each stream has been flushed. As a result, every invalid window the checker counts starts from a clean, edge-aligned event.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_FILL  = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ecc_stage_align.sv
module ecc_stage_align #(
    parameter int NSTAGE = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2*NSTAGE-1:0]   raw_codes,
    output logic [2*NSTAGE-1:0]   aligned_codes
);

    // Stage g (0-based) is needed NSTAGE-g edges after it appears, so its
    // lane is NSTAGE-g registers long; the last stage gets a single register.
    for (genvar g = 0; g < NSTAGE; g++) begin : g_lane
        localparam int DEPTH = NSTAGE - g;
        logic [1:0] tap [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int j = 0; j < DEPTH; j++) begin
                    tap[j] <= '0;
                end
            end else begin
                tap[0] <= raw_codes[2*g +: 2];
                for (int j = 1; j < DEPTH; j++) begin
                    tap[j] <= tap[j-1];
                end
            end
        end

        assign aligned_codes[2*g +: 2] = tap[DEPTH-1];
    end

endmodule

// File: rtl/ecc_overlap_add.sv
module ecc_overlap_add #(
    parameter int NSTAGE = 9
) (
    input  logic [2*NSTAGE-1:0]   aligned_codes,
    output logic [NSTAGE:0]       word
);

    localparam int OUT_W  = NSTAGE + 1;
    localparam int SUM_W  = OUT_W + 3;
    localparam int MAXV   = (1 << OUT_W) - 1;

    logic [NSTAGE-1:0]          prev_hi;
    logic signed [SUM_W-1:0]    acc;
    logic signed [2:0]          digit;
    logic [1:0]                 code;

    // Upper bit of the preceding stage's code; stage 1 has no predecessor
    // and always resolves an out-of-range mark upward.
    always_comb begin
        prev_hi[0] = 1'b1;
        for (int i = 1; i < NSTAGE; i++) begin
            prev_hi[i] = aligned_codes[2*i-1];
        end
    end

    always_comb begin
        acc   = '0;
        digit = '0;
        code  = '0;
        for (int i = 0; i < NSTAGE - 1; i++) begin
            code = aligned_codes[2*i +: 2];
            if (code == 2'b11) begin
                digit = prev_hi[i] ? 3'sd3 : -3'sd1;
            end else begin
                digit = signed'({1'b0, code});
            end
            acc = acc + (SUM_W'(digit) <<< (NSTAGE - 1 - i));
        end
        acc = acc + signed'(SUM_W'(aligned_codes[2*NSTAGE-1 -: 2]));
    end

    always_comb begin
        if (int'(acc) < 0) begin
            word = '0;
        end else if (int'(acc) > MAXV) begin
            word = '1;
        end else begin
            word = acc[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/ecc_seq_ctrl.sv
module ecc_seq_ctrl
    import ecc_pkg::*;
#(
    parameter int LATENCY = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic pwrdn,
    input  logic oe_n,
    output logic dvalid,
    output logic drive_en
);

    localparam int                CNT_W     = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0]  FILL_LAST = CNT_W'(LATENCY - 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FILL: begin
                if (pwrdn) begin
                    state_d = ST_SLEEP;
                    cnt_d   = '0;
                end else if (cnt_q == FILL_LAST) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (pwrdn) begin
                    state_d = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (!pwrdn) begin
                    state_d = ST_FILL;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_FILL;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        dvalid   = (state_q == ST_RUN);
        drive_en = !oe_n && !pwrdn;
    end

endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector #(
    parameter int NSTAGE  = 9,
    parameter int LATENCY = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2*NSTAGE-1:0]   stage_codes,
    input  logic                  oe_n,
    input  logic                  pwrdn,
    output logic [NSTAGE:0]       dout,
    output logic                  dout_oe,
    output logic                  dvalid
);

    localparam int OUT_W     = NSTAGE + 1;
    localparam int OUT_STAGE = LATENCY - 1;

    logic [2*NSTAGE-1:0]  aligned;
    logic [OUT_W-1:0]     merged;
    logic [OUT_W-1:0]     pipe_q [OUT_STAGE];

    ecc_stage_align #(.NSTAGE(NSTAGE)) u_align (
        .clk           (clk),
        .rst           (rst),
        .raw_codes     (stage_codes),
        .aligned_codes (aligned)
    );

    ecc_overlap_add #(.NSTAGE(NSTAGE)) u_merge (
        .aligned_codes (aligned),
        .word          (merged)
    );

    ecc_seq_ctrl #(.LATENCY(LATENCY)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .pwrdn    (pwrdn),
        .oe_n     (oe_n),
        .dvalid   (dvalid),
        .drive_en (dout_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < OUT_STAGE; j++) begin
                pipe_q[j] <= '0;
            end
        end else begin
            pipe_q[0] <= merged;
            for (int j = 1; j < OUT_STAGE; j++) begin
                pipe_q[j] <= pipe_q[j-1];
            end
        end
    end

    assign dout = pipe_q[OUT_STAGE-1];

endmodule

// File: rtl/ecc_corrector_chk.sv
module ecc_corrector_chk #(
    parameter int NSTAGE  = 9,
    parameter int LATENCY = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           oe_n,
    input logic           pwrdn,
    input logic [NSTAGE:0] dout,
    input logic           dout_oe,
    input logic           dvalid
);

    // Edges since the last reset or power-down sample, saturating.
    logic [15:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst || pwrdn) begin
            quiet_q <= '0;
        end else if (quiet_q != '1) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!dvalid && dout == '0));

    a_r6_oe_disables: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_oe);

    a_r7_pwrdn_disables: assert property (@(posedge clk) disable iff (rst)
        pwrdn |-> !dout_oe);

    a_r7_pwrdn_invalid: assert property (@(posedge clk) disable iff (rst)
        pwrdn |=> !dvalid);

    a_r8_fill_window: assert property (@(posedge clk) disable iff (rst)
        dvalid |-> (quiet_q >= 16'(LATENCY)));

endmodule

bind ecc_corrector ecc_corrector_chk #(.NSTAGE(NSTAGE), .LATENCY(LATENCY)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .oe_n    (oe_n),
    .pwrdn   (pwrdn),
    .dout    (dout),
    .dout_oe (dout_oe),
    .dvalid  (dvalid)
);

// File: tb/test_ecc_corrector.sv
module test_ecc_corrector;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] codes = '0;
    logic        oe_n = 1'b0;
    logic        pwrdn = 1'b0;
    logic [9:0]  dout;
    logic        dout_oe;
    logic        dvalid;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int seed  = 7;
    bit done  = 0;

    logic [17:0] hist [9];
    int          exp_w  [8192];
    bit          exp_on [8192];

    always #5 clk = ~clk;

    ecc_corrector i_ecc_corrector (
        .clk         (clk),
        .rst         (rst),
        .stage_codes (codes),
        .oe_n        (oe_n),
        .pwrdn       (pwrdn),
        .dout        (dout),
        .dout_oe     (dout_oe),
        .dvalid      (dvalid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int model(input logic [17:0] s);
        int acc = 0;
        for (int i = 0; i < 8; i++) begin
            int d = int'(s[2*i +: 2]);
            if (d == 3) d = (i == 0 || s[2*i-1]) ? 3 : -1;
            acc += d * (1 << (8 - i));
        end
        acc += int'(s[17:16]);
        if (acc < 0) acc = 0;
        if (acc > 1023) acc = 1023;
        return acc;
    endfunction

    function automatic logic [17:0] pat(input logic [1:0] rest, input logic [1:0] last);
        return {last, {8{rest}}};
    endfunction

    function automatic logic [17:0] rnd();
        logic [17:0] s;
        for (int i = 0; i < 9; i++) begin
            seed = seed * 1103515245 + 12345;
            s[2*i +: 2] = (i == 8) ? 2'((seed >>> 16) & 3) : 2'(((seed >>> 16) & 32'h7fff) % 3);
        end
        return s;
    endfunction

    // One sample per clock; stage k is fed from the sample pushed k-1 clocks ago.
    task automatic push(input logic [17:0] s, input bit want, input string tag);
        for (int i = 8; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = s;
        for (int i = 0; i < 9; i++) codes[2*i +: 2] = hist[i][2*i +: 2];
        exp_w[cyc % 8192]  = model(s);
        exp_on[cyc % 8192] = want;
        @(posedge clk);
        cyc++;
        @(negedge clk);
        if (cyc >= 13 && exp_on[(cyc - 13) % 8192]) begin
            check(dout == 10'(exp_w[(cyc - 13) % 8192]), tag, int'(dout), exp_w[(cyc - 13) % 8192]);
            check(dvalid == 1'b1, tag, int'(dvalid), 1);
        end
    endtask

    task automatic flush();
        for (int j = 0; j < 13; j++) push('0, 1'b0, "flush");
    endtask

    task automatic t_reset_fill();
        for (int j = 0; j < 12; j++) push(pat(2'b10, 2'b11), 1'b0, "dirty");
        rst = 1'b1;
        for (int i = 0; i < 9; i++) hist[i] = '0;
        push('0, 1'b0, "rst");
        push('0, 1'b0, "rst");
        check(dvalid == 1'b0, "R9 valid low in reset", int'(dvalid), 0);
        check(dout == '0, "R9 dout cleared", int'(dout), 0);
        check(dout_oe == 1'b1, "R9 drive enabled", int'(dout_oe), 1);
        rst = 1'b0;
        for (int j = 1; j <= 5; j++) begin
            push('0, 1'b0, "fill");
            check(dvalid == (j == 5), "R9 valid after fifth edge", int'(dvalid), int'(j == 5));
            check(dout == '0, "R9 delay lines cleared", int'(dout), 0);
        end
        flush();
    endtask

    task automatic t_fixed();
        push(pat(2'b01, 2'b10), 1'b1, "R2 midscale 0x200");
        push(pat(2'b10, 2'b11), 1'b1, "R2 full scale 0x3FF");
        push(pat(2'b00, 2'b00), 1'b1, "R2 zero scale");
        flush();
        check(model(pat(2'b01, 2'b10)) == 'h200, "R2 midscale model", model(pat(2'b01, 2'b10)), 'h200);
    endtask

    task automatic t_latency();
        int e;
        e = cyc;
        push(pat(2'b01, 2'b01), 1'b0, "R5 lat");
        for (int j = 0; j < 13; j++) begin
            push('0, 1'b0, "R5 lat");
            if (cyc == e + 12) check(dout == '0, "R5 not yet", int'(dout), 0);
            if (cyc == e + 13) check(dout == 10'h1FF, "R5 fifth edge", int'(dout), 'h1FF);
        end
    endtask

    task automatic t_stream();
        for (int j = 0; j < 40; j++) push(rnd(), 1'b1, "R1 aligned stream");
        flush();
    endtask

    task automatic t_redundant();
        logic [17:0] s;
        int e;
        e = cyc;
        s = pat(2'b01, 2'b10);
        s[15:14] = 2'b11;
        push(s, 1'b1, "R3 low-resolved mark");
        s = '0;
        s[1:0] = 2'b01; s[3:2] = 2'b10; s[5:4] = 2'b11;
        push(s, 1'b1, "R3 high-resolved mark");
        for (int j = 0; j < 13; j++) begin
            push('0, 1'b0, "R3");
            if (cyc == e + 13) check(dout == 10'h1FC, "R3 digit -1", int'(dout), 'h1FC);
            if (cyc == e + 14) check(dout == 10'h2C0, "R3 digit 3", int'(dout), 'h2C0);
        end
    endtask

    task automatic t_clamp();
        logic [17:0] s;
        int e;
        e = cyc;
        s = pat(2'b10, 2'b11);
        s[1:0] = 2'b11;
        push(s, 1'b1, "R4 clamp high");
        s = '0;
        s[7:6] = 2'b11;
        push(s, 1'b1, "R4 clamp low");
        push(pat(2'b10, 2'b11), 1'b1, "R4 top no clamp");
        for (int j = 0; j < 13; j++) begin
            push('0, 1'b0, "R4");
            if (cyc == e + 13) check(dout == 10'h3FF, "R4 high literal", int'(dout), 'h3FF);
            if (cyc == e + 14) check(dout == 10'h000, "R4 low literal", int'(dout), 0);
        end
    endtask

    task automatic t_oe();
        oe_n = 1'b1;
        #1;
        check(dout_oe == 1'b0, "R6 disabled", int'(dout_oe), 0);
        for (int j = 0; j < 20; j++) begin
            push(rnd(), 1'b1, "R6 data flows while disabled");
            check(dout_oe == 1'b0, "R6 stays disabled", int'(dout_oe), 0);
        end
        flush();
        oe_n = 1'b0;
        #1;
        check(dout_oe == 1'b1, "R6 re-enabled", int'(dout_oe), 1);
    endtask

    task automatic t_pwrdn();
        pwrdn = 1'b1;
        #1;
        check(dout_oe == 1'b0, "R7 pads off", int'(dout_oe), 0);
        for (int j = 0; j < 4; j++) begin
            push(rnd(), 1'b0, "R7");
            check(dvalid == 1'b0, "R7 invalid asleep", int'(dvalid), 0);
            check(dout_oe == 1'b0, "R7 pads off", int'(dout_oe), 0);
        end
        pwrdn = 1'b0;
        #1;
        check(dout_oe == 1'b1, "R7 pads back", int'(dout_oe), 1);
        for (int j = 1; j <= 6; j++) begin
            push(rnd(), 1'b0, "R8");
            check(dvalid == (j == 6), "R8 five invalid words", int'(dvalid), int'(j == 6));
        end
        for (int j = 0; j < 20; j++) push(rnd(), 1'b1, "R8 data after wake");
        flush();
    endtask

    initial begin
        for (int i = 0; i < 9; i++) hist[i] = '0;
        for (int i = 0; i < 8192; i++) exp_on[i] = 1'b0;
        @(negedge clk);
        t_reset_fill();
        t_fixed();
        t_latency();
        t_stream();
        t_redundant();
        t_clamp();
        t_oe();
        t_pwrdn();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule